// File: doc/BRIEF.md
# Frame-Rate-Control Grayscale Modulator

This block lets a panel that can only switch each subpixel fully on or fully off show intermediate brightness. Each color channel arrives as a multi-bit level. For every frame the block picks a single on/off bit per channel, so that over a repeating cycle of frames the fraction of on-frames matches the level. The repeating cycle is 2^LEVEL_W frames long, which is 16 frames by default.

Two pattern tables have the same on-count for every level. They differ in phase. Which table a pixel uses depends on the parity of its row and column, so neighbouring pixels follow different patterns wherever the shift changes the pattern. A host stream feeds one pixel per cycle with a valid flag, the frame counter, and the low bits of the pixel's row and column. The block returns the channel bits one register later, together with a delayed valid.

Top module: `frc_modulator`

## Requirements
- R1: While rst_ni is low, valid_o and every bit of pix_o are 0.
- R2: valid_o after a rising clock edge equals valid_i sampled at that edge, which is a one-cycle latency. Nothing changes at the outputs before that edge.
- R3: A channel whose level is 0 gives a 0 bit in every frame, for both tables.
- R4: A channel at level 15 gives 1 in 15 of the 16 frames. Its single off frame is frame 15 under table A and frame 7 under table B.
- R5: Over the 16 frame values 0..15, a channel at level N is on in exactly N frames, under either table.
- R6: Table A turns a channel on when rank < level. The rank is the frame value with its 4 bits reversed: frame bit 3 becomes rank bit 0, and frame bit 0 becomes rank bit 3.
- R7: At level 8, a channel is on in frames with frame bit 0 = 0 and off in frames with frame bit 0 = 1, so it alternates every frame.
- R8: The table is chosen by row_par_i XOR col_par_i. A result of 0 selects table A and a result of 1 selects table B.
- R9: Table B at frame f gives the same bit as table A at frame (f + 8) mod 16.
- R10: Channel c takes its level from level_i[4c+3:4c] and drives pix_o[c]. It is independent of the other channels.
- R11: When valid_i is 0 at an edge, pix_o is all zeros after that edge, whatever the levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel valid |
| level_i | input | N_CH*LEVEL_W | Packed channel levels, channel 0 in the low bits |
| frame_i | input | LEVEL_W | Frame counter, low bits |
| row_par_i | input | 1 | Bit 0 of the pixel row |
| col_par_i | input | 1 | Bit 0 of the pixel column |
| valid_o | output | 1 | Output valid, delayed by one cycle |
| pix_o | output | N_CH | On/off bit per channel |

## Verification
Two selection paths meet in the same cycle: the checkerboard table choice and the per-channel level comparison. The bench sweeps every level against all 16 frames under all four parity combinations. Each sample is judged against a reference built from the bit-reverse rule and the 8-frame shift. The valid gating and the level comparison also coincide. Those are provoked by dropping valid_i while full-scale levels are applied, and the bench expects zeros that cycle and the correct bits the cycle after valid_i returns.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic {TBL_A = 1'b0, TBL_B = 1'b1} tbl_sel_e;
endpackage

// File: rtl/frc_phase_sel.sv
module frc_phase_sel
  import frc_pkg::*;
#(
  parameter int LEVEL_W = 4,
  parameter int SHIFT   = 8
) (
  input  logic [LEVEL_W-1:0] frame_i,
  input  logic               row_par_i,
  input  logic               col_par_i,
  output tbl_sel_e           tbl_o,
  output logic [LEVEL_W-1:0] rank_o
);
  localparam logic [LEVEL_W-1:0] SHIFT_V = LEVEL_W'(SHIFT);

  logic [LEVEL_W-1:0] phase;

  assign tbl_o = (row_par_i ^ col_par_i) ? TBL_B : TBL_A;
  assign phase = frame_i + ((tbl_o == TBL_B) ? SHIFT_V : '0);

  // bit-reversed phase spreads on-frames evenly over the cycle
  always_comb begin
    for (int i = 0; i < LEVEL_W; i++) rank_o[i] = phase[LEVEL_W-1-i];
  end
endmodule

// File: rtl/frc_level_cmp.sv
module frc_level_cmp #(
  parameter int LEVEL_W = 4
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0] rank_i,
  output logic               on_o
);
  assign on_o = (rank_i < level_i);
endmodule

// File: rtl/frc_modulator.sv
module frc_modulator
  import frc_pkg::*;
#(
  parameter int N_CH    = 3,
  parameter int LEVEL_W = 4,
  parameter int SHIFT   = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [N_CH*LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0]      frame_i,
  input  logic                    row_par_i,
  input  logic                    col_par_i,
  output logic                    valid_o,
  output logic [N_CH-1:0]         pix_o
);
  tbl_sel_e           tbl;
  logic [LEVEL_W-1:0] rank;
  logic [N_CH-1:0]    pix_d;

  frc_phase_sel #(.LEVEL_W(LEVEL_W), .SHIFT(SHIFT)) u_phase (
    .frame_i  (frame_i),
    .row_par_i(row_par_i),
    .col_par_i(col_par_i),
    .tbl_o    (tbl),
    .rank_o   (rank)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    frc_level_cmp #(.LEVEL_W(LEVEL_W)) u_cmp (
      .level_i(level_i[c*LEVEL_W +: LEVEL_W]),
      .rank_i (rank),
      .on_o   (pix_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= valid_i;
      pix_o   <= valid_i ? pix_d : '0;
    end
  end
endmodule

// File: rtl/frc_modulator_chk.sv
module frc_modulator_chk #(
  parameter int N_CH    = 3,
  parameter int LEVEL_W = 4,
  parameter int SHIFT   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic [N_CH*LEVEL_W-1:0] level_i,
  input logic [LEVEL_W-1:0]      frame_i,
  input logic                    row_par_i,
  input logic                    col_par_i,
  input logic                    valid_o,
  input logic [N_CH-1:0]         pix_o
);
  localparam logic [LEVEL_W-1:0] MAX_V   = '1;
  localparam logic [LEVEL_W-1:0] OFF_B_V = MAX_V - LEVEL_W'(SHIFT);

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_idle_r1: assert (valid_o == 1'b0 && pix_o == '0);
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> pix_o == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    p_zero_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(level_i[c*LEVEL_W +: LEVEL_W]) == '0) |-> !pix_o[c]);

    p_full_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(valid_i) && $past(level_i[c*LEVEL_W +: LEVEL_W]) == MAX_V &&
       $past(frame_i) != (($past(row_par_i) ^ $past(col_par_i)) ? OFF_B_V : MAX_V))
      |-> pix_o[c]);

    p_mid_toggle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(valid_i) &&
       $past(level_i[c*LEVEL_W +: LEVEL_W]) == (MAX_V >> 1) + 1'b1)
      |-> pix_o[c] == !$past(frame_i[0]));
  end
endmodule

bind frc_modulator frc_modulator_chk #(.N_CH(N_CH), .LEVEL_W(LEVEL_W), .SHIFT(SHIFT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .level_i  (level_i),
  .frame_i  (frame_i),
  .row_par_i(row_par_i),
  .col_par_i(col_par_i),
  .valid_o  (valid_o),
  .pix_o    (pix_o)
);

// File: tb/test_frc_modulator.sv
`timescale 1ns/1ps
module test_frc_modulator;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] level_i = '0;
  logic [3:0]  frame_i = '0;
  logic        row_par_i = 1'b0;
  logic        col_par_i = 1'b0;
  logic        valid_o;
  logic [2:0]  pix_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  frc_modulator i_frc_modulator (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .level_i(level_i),
    .frame_i(frame_i), .row_par_i(row_par_i), .col_par_i(col_par_i),
    .valid_o(valid_o), .pix_o(pix_o)
  );

  function automatic bit ref_on(input int lvl, input int frm, input bit sel);
    int ph = (frm + (sel ? 8 : 0)) % 16;
    int rk = 0;
    for (int i = 0; i < 4; i++) if (ph[i]) rk |= (1 << (3 - i));
    return rk < lvl;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next rising edge
  task automatic step(input bit v, input int l0, input int l1, input int l2,
                      input int f, input bit r, input bit c);
    @(negedge clk_i);
    valid_i = v; level_i = {4'(l2), 4'(l1), 4'(l0)};
    frame_i = 4'(f); row_par_i = r; col_par_i = c;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset;
    #1;
    check("R1 valid", valid_o, 0);
    check("R1 pix", pix_o, 0);
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 valid hold", valid_o, 0);
    check("R1 pix hold", pix_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_latency;
    @(negedge clk_i);
    valid_i = 1'b1; level_i = {4'd15, 4'd15, 4'd15}; frame_i = 4'd0;
    #1;
    check("R2 before edge", valid_o, 0);
    @(posedge clk_i); #1;
    check("R2 after edge", valid_o, 1);
    check("R2 data", pix_o, 3'b111);
    step(0, 15, 15, 15, 0, 0, 0);
    check("R2 drop", valid_o, 0);
  endtask

  task automatic t_zero_full;
    for (int s = 0; s < 2; s++) begin
      int z = 0;
      int on15 = 0;
      int offf = -1;
      for (int f = 0; f < 16; f++) begin
        step(1, 0, 15, 0, f, 1'b0, s[0]);
        if (pix_o[0] || pix_o[2]) z++;
        if (pix_o[1]) on15++; else offf = f;
      end
      check("R3 level0 on-count", z, 0);
      check("R4 level15 on-count", on15, 15);
      check("R4 level15 off frame", offf, s ? 7 : 15);
    end
  endtask

  task automatic t_duty;
    for (int s = 0; s < 4; s++) begin
      bit r = s[1];
      bit c = s[0];
      bit sel = r ^ c;
      for (int l = 0; l < 16; l++) begin
        int cnt = 0;
        int bad = 0;
        for (int f = 0; f < 16; f++) begin
          step(1, l, 0, 0, f, r, c);
          if (pix_o[0]) cnt++;
          if (pix_o[0] != ref_on(l, f, sel)) bad++;
        end
        check("R5 duty", cnt, l);
        check(sel ? "R8 table B pattern" : "R6 table A pattern", bad, 0);
      end
    end
  endtask

  task automatic t_mid;
    for (int f = 0; f < 16; f++) begin
      step(1, 8, 8, 8, f, 1'b1, 1'b0);
      check("R7 mid toggle", pix_o, f[0] ? 0 : 7);
    end
  endtask

  task automatic t_shift;
    for (int f = 0; f < 16; f++) begin
      bit a;
      bit b;
      step(1, 3, 0, 0, (f + 8) % 16, 1'b1, 1'b1);
      a = pix_o[0];
      step(1, 3, 0, 0, f, 1'b0, 1'b1);
      b = pix_o[0];
      check("R9 B equals shifted A", b, a);
    end
  endtask

  task automatic t_channels;
    int lv[3] = '{1, 6, 13};
    for (int f = 0; f < 16; f++) begin
      int exp = 0;
      step(1, lv[0], lv[1], lv[2], f, 1'b0, 1'b1);
      for (int c = 0; c < 3; c++) if (ref_on(lv[c], f, 1'b1)) exp |= (1 << c);
      check("R10 channel map", pix_o, exp);
    end
  endtask

  task automatic t_idle;
    step(0, 15, 15, 15, 3, 1'b0, 1'b0);
    check("R11 idle pix", pix_o, 0);
    step(0, 8, 8, 8, 0, 1'b1, 1'b0);
    check("R11 idle pix mid", pix_o, 0);
    step(1, 15, 15, 15, 3, 1'b0, 1'b0);
    check("R11 resume", pix_o, 7);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_zero_full();
    t_duty();
    t_mid();
    t_shift();
    t_channels();
    t_idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule